// File: doc/BRIEF.md
# ASID-Tagged Fully Associative Translation Buffer

This block caches virtual-to-physical page translations for a processor pipeline. Every entry can hold any virtual page, and each entry carries an address-space tag. Translations from different processes can therefore stay resident across a context switch without a flush. A lookup is combinational and resolves in the same cycle. It returns the physical address together with the stored dirty and reference state of the entry. It reports a miss when no entry matches, so that a software refill routine can load one. It reports a protection fault when an entry matches but its rights forbid the access.

The three top bits of the virtual address select the region. When bit 31 is 0, the access is a translated user region. The value 100 selects a cached kernel window that is not translated. The value 101 selects the same window uncached. The value 11x selects a translated kernel region.

Software maintains the table through three operations:
- A write loads an entry, either at an explicit index or at a pseudo-random victim index. The victim index never falls on the reserved low entries.
- An invalidate clears every entry that maps one virtual page.
- A flush clears the whole table.

Top module: `xlate_tlb`

## Requirements
- R1: While reset is asserted and after it, every entry is invalid, so a lookup in a translated region reports a miss. The victim index starts at N_ENTRIES-1.
- R2: When the top three address bits are 100 or 101, the lookup reports a hit with no table access. The physical address is the virtual address with its top three bits cleared. `lk_uncached` is 1 only for 101.
- R3: When the top bits are 0xx or 11x, a lookup hits if a valid entry matches the virtual page number (bits 31:12) and its ASID equals `cur_asid` or its global bit is set. The physical address is {pfn, vaddr[11:0]}, and `lk_dirty` reports the stored dirty bit.
- R4: A non-global entry whose ASID differs from `cur_asid` does not match.
- R5: A translated lookup with no matching entry raises `lk_miss` with `lk_hit` low.
- R6: The rights field uses bit 0 to allow reads and bit 1 to allow writes. A matching lookup whose access is not allowed raises `lk_prot_fault`, with `lk_hit` and `lk_miss` both low.
- R7: A write loads the entry at `wr_index`, or at `victim_idx` when `wr_random` is 1. The new content is visible from the next cycle. A lookup in the same cycle as the write sees the old content.
- R8: `victim_idx` stays within N_RSVD..N_ENTRIES-1. It decrements every cycle and wraps from N_RSVD to N_ENTRIES-1.
- R9: An invalidate clears every entry matching `inv_vpn` and either `inv_asid` or the global bit. A write to the same entry in the same cycle takes precedence.
- R10: A flush clears every entry and overrides a write in the same cycle. The untranslated regions still hit afterwards.
- R11: `lk_ref` shows the stored reference bit of the entry that hit. A hit sets that bit, and a write loads it as 0.
- R12: When several entries match, the lowest index supplies the translation.
- R13: With `lk_valid` low, `lk_hit`, `lk_miss` and `lk_prot_fault` stay low and no reference bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Access is a store |
| cur_asid | input | 6 | Current address-space identifier |
| lk_hit | output | 1 | Translation available |
| lk_miss | output | 1 | No matching entry |
| lk_prot_fault | output | 1 | Entry matched but access not allowed |
| lk_paddr | output | 32 | Physical address (0 unless hit) |
| lk_uncached | output | 1 | Access bypasses the data cache |
| lk_dirty | output | 1 | Dirty bit of the hit entry |
| lk_ref | output | 1 | Reference bit of the hit entry before this lookup |
| wr_en | input | 1 | Load an entry |
| wr_random | input | 1 | Use the victim index instead of wr_index |
| wr_index | input | 6 | Explicit entry index |
| wr_vpn | input | 20 | Virtual page number |
| wr_asid | input | 6 | Entry ASID |
| wr_global | input | 1 | Entry matches any ASID |
| wr_pfn | input | 20 | Physical page number |
| wr_dirty | input | 1 | Dirty bit |
| wr_rights | input | 2 | Bit 0 read allowed, bit 1 write allowed |
| wr_valid | input | 1 | Valid bit |
| inv_en | input | 1 | Invalidate by page |
| inv_vpn | input | 20 | Page to invalidate |
| inv_asid | input | 6 | ASID qualifying the invalidate |
| flush_all | input | 1 | Clear every entry |
| victim_idx | output | 6 | Current replacement index |

## Verification
A lookup can coincide with a write that targets the entry being looked up, and an invalidate can coincide with a write to the same entry. The bench provokes both by driving the two operations in one cycle. It expects the lookup to miss in that cycle and to hit from the next cycle. It expects the write to survive the invalidate. It also drives a flush together with a write and expects the written page to miss afterwards. A hit that updates the reference bit in the same cycle as a write to that entry is judged by the next lookup reporting a reference bit of 0.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;
  localparam int VA_W   = 32;
  localparam int PG_W   = 12;
  localparam int VPN_W  = VA_W - PG_W;
  localparam int PFN_W  = 20;
  localparam int PA_W   = PFN_W + PG_W;
  localparam int ASID_W = 6;

  typedef enum logic [1:0] {
    SEG_USER      = 2'd0,
    SEG_KDIRECT   = 2'd1,
    SEG_KDIRECT_NC= 2'd2,
    SEG_KMAPPED   = 2'd3
  } seg_e;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [PFN_W-1:0]  pfn;
    logic              dirty;
    logic              refd;
    logic              valid;
    logic [1:0]        rights;
  } entry_t;

  // Region select from the three top address bits.
  function automatic seg_e seg_of(input logic [VA_W-1:0] va);
    logic [2:0] top;
    top = va[VA_W-1 -: 3];
    if (!top[2])          return SEG_USER;
    else if (top[1])      return SEG_KMAPPED;
    else if (top[0])      return SEG_KDIRECT_NC;
    else                  return SEG_KDIRECT;
  endfunction

  function automatic logic seg_mapped(input seg_e s);
    return (s == SEG_USER) || (s == SEG_KMAPPED);
  endfunction

  function automatic logic tag_match(input entry_t e,
                                     input logic [VPN_W-1:0] vpn,
                                     input logic [ASID_W-1:0] asid);
    return e.valid && (e.vpn == vpn) && (e.glob || (e.asid == asid));
  endfunction

  // rights[0] permits loads, rights[1] permits stores.
  function automatic logic access_ok(input logic [1:0] rights, input logic is_wr);
    return is_wr ? rights[1] : rights[0];
  endfunction

  function automatic logic [PA_W-1:0] direct_pa(input logic [VA_W-1:0] va);
    return PA_W'(va[VA_W-4:0]);
  endfunction

  function automatic logic [PA_W-1:0] mapped_pa(input logic [PFN_W-1:0] pfn,
                                                input logic [VA_W-1:0] va);
    return {pfn, va[PG_W-1:0]};
  endfunction
endpackage

// File: rtl/xtlb_victim.sv
module xtlb_victim #(
  parameter int N_ENTRIES = 64,
  parameter int N_RSVD    = 8,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] victim
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(N_ENTRIES - 1);
  localparam logic [IDX_W-1:0] LOW = IDX_W'(N_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             victim <= TOP;
    else if (victim == LOW) victim <= TOP;
    else                    victim <= victim - 1'b1;
  end
endmodule

// File: rtl/xtlb_cam.sv
module xtlb_cam
  import xtlb_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              ref_set,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  entry_t            wr_entry,
  input  logic              inv_en,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic              flush,
  output logic              hit_any,
  output logic [IDX_W-1:0]  hit_idx,
  output entry_t            hit_entry,
  output logic              any_valid
);
  entry_t               ent [N_ENTRIES];
  logic [N_ENTRIES-1:0] mvec;
  logic [N_ENTRIES-1:0] ivec;
  logic [N_ENTRIES-1:0] vvec;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
    assign mvec[i] = tag_match(ent[i], lk_vpn, lk_asid);
    assign ivec[i] = tag_match(ent[i], inv_vpn, inv_asid);
    assign vvec[i] = ent[i].valid;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent[i] <= '0;
      end else if (flush) begin
        ent[i].valid <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        ent[i] <= wr_entry;
      end else begin
        if (inv_en && ivec[i]) ent[i].valid <= 1'b0;
        if (ref_set && (hit_idx == IDX_W'(i))) ent[i].refd <= 1'b1;
      end
    end
  end

  // Lowest matching index wins.
  always_comb begin
    hit_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (mvec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit_any   = |mvec;
  assign hit_entry = ent[hit_idx];
  assign any_valid = |vvec;
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
  import xtlb_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  parameter int N_RSVD    = 8,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              lk_write,
  input  logic [ASID_W-1:0] cur_asid,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_prot_fault,
  output logic [PA_W-1:0]   lk_paddr,
  output logic              lk_uncached,
  output logic              lk_dirty,
  output logic              lk_ref,
  input  logic              wr_en,
  input  logic              wr_random,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_dirty,
  input  logic [1:0]        wr_rights,
  input  logic              wr_valid,
  input  logic              inv_en,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic              flush_all,
  output logic [IDX_W-1:0]  victim_idx
);
  seg_e             seg;
  logic             is_mapped;
  logic             cam_hit;
  logic [IDX_W-1:0] cam_idx;
  entry_t           cam_ent;
  logic             any_valid;
  logic             perm_ok;
  entry_t           new_ent;
  logic [IDX_W-1:0] wr_slot;

  // Named events for the checker.
  logic ev_direct, ev_tlb_hit, ev_prot, ev_miss;

  assign seg       = seg_of(lk_vaddr);
  assign is_mapped = seg_mapped(seg);
  assign perm_ok   = access_ok(cam_ent.rights, lk_write);

  assign ev_direct  = lk_valid && !is_mapped;
  assign ev_tlb_hit = lk_valid && is_mapped && cam_hit && perm_ok;
  assign ev_prot    = lk_valid && is_mapped && cam_hit && !perm_ok;
  assign ev_miss    = lk_valid && is_mapped && !cam_hit;

  assign new_ent = '{vpn: wr_vpn, asid: wr_asid, glob: wr_global, pfn: wr_pfn,
                     dirty: wr_dirty, refd: 1'b0, valid: wr_valid, rights: wr_rights};
  assign wr_slot = wr_random ? victim_idx : wr_index;

  xtlb_victim #(.N_ENTRIES(N_ENTRIES), .N_RSVD(N_RSVD)) u_victim (
    .clk(clk), .rst_n(rst_n), .victim(victim_idx)
  );

  xtlb_cam #(.N_ENTRIES(N_ENTRIES)) u_cam (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(lk_vaddr[VA_W-1:PG_W]), .lk_asid(cur_asid),
    .ref_set(ev_tlb_hit),
    .wr_en(wr_en), .wr_idx(wr_slot), .wr_entry(new_ent),
    .inv_en(inv_en), .inv_vpn(inv_vpn), .inv_asid(inv_asid),
    .flush(flush_all),
    .hit_any(cam_hit), .hit_idx(cam_idx), .hit_entry(cam_ent),
    .any_valid(any_valid)
  );

  always_comb begin
    lk_paddr = '0;
    if (ev_direct)       lk_paddr = direct_pa(lk_vaddr);
    else if (ev_tlb_hit) lk_paddr = mapped_pa(cam_ent.pfn, lk_vaddr);
  end

  assign lk_hit        = ev_direct || ev_tlb_hit;
  assign lk_miss       = ev_miss;
  assign lk_prot_fault = ev_prot;
  assign lk_uncached   = ev_direct && (seg == SEG_KDIRECT_NC);
  assign lk_dirty      = ev_tlb_hit && cam_ent.dirty;
  assign lk_ref        = ev_tlb_hit && cam_ent.refd;
endmodule

// File: rtl/xlate_tlb_chk.sv
module xlate_tlb_chk #(
  parameter int N_ENTRIES = 64,
  parameter int N_RSVD    = 8,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [31:0]      lk_vaddr,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_prot_fault,
  input logic [31:0]      lk_paddr,
  input logic             lk_uncached,
  input logic             flush_all,
  input logic             any_valid,
  input logic [IDX_W-1:0] victim_idx
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(N_ENTRIES - 1);
  localparam logic [IDX_W-1:0] LOW = IDX_W'(N_RSVD);

  p_outcome_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_miss, lk_prot_fault}));

  p_direct_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_vaddr[31:30] == 2'b10) |-> (lk_hit && lk_paddr[31:29] == 3'b000
      && lk_paddr[28:0] == lk_vaddr[28:0] && lk_uncached == lk_vaddr[29]));

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss || lk_prot_fault));

  p_victim_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    victim_idx >= LOW);

  p_victim_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (victim_idx == (($past(victim_idx) == LOW) ? TOP : $past(victim_idx) - 1'b1)));

  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !any_valid);

  p_fault_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_prot_fault |-> (lk_valid && lk_paddr == '0));
endmodule

bind xlate_tlb xlate_tlb_chk #(.N_ENTRIES(N_ENTRIES), .N_RSVD(N_RSVD)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_prot_fault(lk_prot_fault),
  .lk_paddr(lk_paddr), .lk_uncached(lk_uncached), .flush_all(flush_all),
  .any_valid(any_valid), .victim_idx(victim_idx)
);

// File: tb/xlate_tlb_bench.sv
module xlate_tlb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 64;
  localparam int RSV = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        lk_valid = 0, lk_write = 0;
  logic [31:0] lk_vaddr = '0;
  logic [5:0]  cur_asid = '0;
  logic        lk_hit, lk_miss, lk_prot_fault, lk_uncached, lk_dirty, lk_ref;
  logic [31:0] lk_paddr;
  logic        wr_en = 0, wr_random = 0, wr_global = 0, wr_dirty = 0, wr_valid = 0;
  logic [5:0]  wr_index = '0, wr_asid = '0, inv_asid = '0;
  logic [19:0] wr_vpn = '0, wr_pfn = '0, inv_vpn = '0;
  logic [1:0]  wr_rights = '0;
  logic        inv_en = 0, flush_all = 0;
  logic [5:0]  victim_idx;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlate_tlb u_xlate_tlb (.*);

  // {hit, miss, fault, uncached, dirty, ref, paddr}
  typedef logic [37:0] exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  function automatic exp_t mk(logic h, logic m, logic f, logic u, logic d, logic r,
                              logic [31:0] pa);
    return {h, m, f, u, d, r, pa};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Monitor: compares every queued expectation against the lookup outputs.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = mk(lk_hit, lk_miss, lk_prot_fault, lk_uncached, lk_dirty, lk_ref, lk_paddr);
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic put(input logic [5:0] idx, input logic rnd, input logic [19:0] vpn,
                     input logic [5:0] asid, input logic g, input logic [19:0] pfn,
                     input logic d, input logic [1:0] rt);
    wr_en = 1; wr_random = rnd; wr_index = idx; wr_vpn = vpn; wr_asid = asid;
    wr_global = g; wr_pfn = pfn; wr_dirty = d; wr_rights = rt; wr_valid = 1;
    tick();
    wr_en = 0; wr_random = 0;
  endtask

  task automatic drive_look(input logic [31:0] va, input logic w, input logic [5:0] asid,
                            input exp_t e, input string tag);
    lk_valid = 1; lk_vaddr = va; lk_write = w; cur_asid = asid;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic look(input logic [31:0] va, input logic w, input logic [5:0] asid,
                      input exp_t e, input string tag);
    drive_look(va, w, asid, e, tag);
    tick();
    lk_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] v;
    repeat (2) @(posedge clk); #1;
    // R1: lookup during reset misses, victim starts at top
    drive_look(32'h0040_1000, 0, 6'd5, mk(0,1,0,0,0,0,0), "R1 reset miss");
    @(negedge clk);
    chk(victim_idx == 6'(N-1), "R1 victim reset", int'(victim_idx), N-1);
    tick();
    lk_valid = 0;
    rst_n = 1;
    look(32'h0040_1000, 0, 6'd5, mk(0,1,0,0,0,0,0), "R1 empty after reset");

    // R8: victim sequence through a wrap
    for (int i = 0; i < 60; i++) begin
      v = victim_idx;
      tick();
      chk(victim_idx == ((v == 6'(RSV)) ? 6'(N-1) : v - 6'd1), "R8 victim step",
          int'(victim_idx), (v == 6'(RSV)) ? N-1 : int'(v) - 1);
      chk(victim_idx >= 6'(RSV), "R8 victim range", int'(victim_idx), RSV);
    end

    // R2: untranslated windows
    look(32'h8123_4567, 0, 6'd0, mk(1,0,0,0,0,0,32'h0123_4567), "R2 cached window");
    look(32'hA123_4567, 1, 6'd0, mk(1,0,0,1,0,0,32'h0123_4567), "R2 uncached window");

    // R3, R11, R4
    put(6'd3, 0, 20'h00401, 6'd5, 0, 20'hABCDE, 1, 2'b11);
    look(32'h0040_1ABC, 0, 6'd5, mk(1,0,0,0,1,0,32'hABCD_EABC), "R3 user hit");
    look(32'h0040_1ABC, 1, 6'd5, mk(1,0,0,0,1,1,32'hABCD_EABC), "R11 ref set by hit");
    look(32'h0040_1ABC, 0, 6'd6, mk(0,1,0,0,0,0,0), "R4 asid mismatch");

    // R3 global kernel-mapped, R6 write to read-only
    put(6'd4, 0, 20'hC0005, 6'd1, 1, 20'h12345, 0, 2'b01);
    look(32'hC000_5010, 0, 6'd9, mk(1,0,0,0,0,0,32'h1234_5010), "R3 global kmapped");
    look(32'hC000_5010, 1, 6'd9, mk(0,0,1,0,0,0,0), "R6 write protect");
    look(32'h7FFF_F000, 0, 6'd5, mk(0,1,0,0,0,0,0), "R5 plain miss");

    // R7: write and lookup of same page in one cycle
    wr_en = 1; wr_random = 0; wr_index = 6'd10; wr_vpn = 20'h00500; wr_asid = 6'd5;
    wr_global = 0; wr_pfn = 20'h00777; wr_dirty = 0; wr_rights = 2'b11; wr_valid = 1;
    drive_look(32'h0050_0004, 0, 6'd5, mk(0,1,0,0,0,0,0), "R7 same-cycle old view");
    tick();
    wr_en = 0; lk_valid = 0;
    look(32'h0050_0004, 0, 6'd5, mk(1,0,0,0,0,0,32'h0077_7004), "R7 visible next cycle");

    // R7/R8: random placement lands on the captured victim index
    v = victim_idx;
    chk(v >= 6'(RSV), "R8 victim not reserved", int'(v), RSV);
    put(6'd0, 1, 20'h00600, 6'd5, 0, 20'h00888, 0, 2'b11);
    look(32'h0060_0000, 0, 6'd5, mk(1,0,0,0,0,0,32'h0088_8000), "R7 random write hit");
    put(v, 0, 20'h00601, 6'd5, 0, 20'h00999, 0, 2'b11);
    look(32'h0060_0000, 0, 6'd5, mk(0,1,0,0,0,0,0), "R7 random slot was victim");

    // R12: duplicate pages, lowest index wins
    put(6'd20, 0, 20'h00700, 6'd5, 0, 20'h00AAA, 0, 2'b11);
    put(6'd15, 0, 20'h00700, 6'd5, 0, 20'h00BBB, 0, 2'b11);
    look(32'h0070_0020, 0, 6'd5, mk(1,0,0,0,0,0,32'h00BB_B020), "R12 lowest index");

    // R9: invalidate
    inv_en = 1; inv_vpn = 20'h00700; inv_asid = 6'd5; tick(); inv_en = 0;
    look(32'h0070_0020, 0, 6'd5, mk(0,1,0,0,0,0,0), "R9 both copies gone");
    inv_en = 1; inv_vpn = 20'h00401; inv_asid = 6'd7; tick(); inv_en = 0;
    look(32'h0040_1000, 0, 6'd5, mk(1,0,0,0,1,1,32'hABCD_E000), "R9 other asid kept");
    inv_en = 1; inv_vpn = 20'hC0005; inv_asid = 6'd2; tick(); inv_en = 0;
    look(32'hC000_5010, 0, 6'd9, mk(0,1,0,0,0,0,0), "R9 global invalidated");
    // R9: write beats invalidate on the same entry
    inv_en = 1; inv_vpn = 20'h00401; inv_asid = 6'd5;
    put(6'd3, 0, 20'h00401, 6'd5, 0, 20'h0CCCC, 0, 2'b11);
    inv_en = 0;
    look(32'h0040_1008, 0, 6'd5, mk(1,0,0,0,0,0,32'h0CCC_C008), "R9 write wins");

    // R11: same-cycle hit and write leaves ref clear
    wr_en = 1; wr_random = 0; wr_index = 6'd3; wr_vpn = 20'h00401; wr_pfn = 20'h0DDDD;
    drive_look(32'h0040_1008, 0, 6'd5, mk(1,0,0,0,0,1,32'h0CCC_C008), "R11 hit during write");
    tick();
    wr_en = 0; lk_valid = 0;
    look(32'h0040_1008, 0, 6'd5, mk(1,0,0,0,0,0,32'h0DDD_D008), "R11 write clears ref");

    // R13: idle lookup has no effect
    put(6'd2, 0, 20'h00900, 6'd5, 0, 20'h00321, 0, 2'b11);
    lk_valid = 0; lk_vaddr = 32'h0090_0000; cur_asid = 6'd5;
    @(negedge clk);
    chk({lk_hit, lk_miss, lk_prot_fault} == 3'b000, "R13 idle quiet",
        int'({lk_hit, lk_miss, lk_prot_fault}), 0);
    tick();
    look(32'h0090_0000, 0, 6'd5, mk(1,0,0,0,0,0,32'h0032_1000), "R13 ref untouched");

    // R10: flush overrides a simultaneous write
    flush_all = 1;
    put(6'd30, 0, 20'h00800, 6'd5, 0, 20'h00444, 0, 2'b11);
    flush_all = 0;
    look(32'h0080_0000, 0, 6'd5, mk(0,1,0,0,0,0,0), "R10 write dropped");
    look(32'h0090_0000, 0, 6'd5, mk(0,1,0,0,0,0,0), "R10 entries cleared");
    look(32'h8000_0040, 0, 6'd5, mk(1,0,0,0,0,0,32'h0000_0040), "R10 direct still hits");

    tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule